// File: doc/BRIEF.md
# Banked Program Counter Sequencer

This block keeps the 13-bit instruction address of a small 4-bit processor core. The address has three fields: a 1-bit bank, a 4-bit page and an 8-bit step. Together they cover 8,192 program words. Each completed instruction is reported to the block as one command. The command carries an operation code and an 8-bit argument, and the block works out the next address from it. It handles plain sequential advance, a page-select prefix, unconditional and flag-tested jumps, two call forms and three return forms.

Two registers hold the destination bank and page for jumps and calls. Only the prefix command writes them with chosen values. Every other command reloads them from the address that results from it. A prefix therefore affects only the command that follows it directly. Without a prefix, a jump or call stays in the current bank and page.

Calls save the return address on an external nibble-wide stack, one nibble per cycle. Returns read it back in the reverse order. The stack pointer is kept inside the block. While a save or restore frame is running, the block raises `busy` and ignores new commands.

Top module: `pcs_sequencer`

## Requirements
- R1: After reset the address is bank 0, page 1, step 00h (`pc_addr` = 0100h). The destination registers hold bank 0 and page 1, the stack pointer is 00h, `busy` is low and neither stack strobe is active.
- R2: A command with code 0, or with any code from 12 to 15, advances the step by one modulo 256. The page and bank do not change, so step FFh wraps to 00h in the same page.
- R3: The prefix command (code 1) loads argument bit 4 into the destination bank and argument bits 3..0 into the destination page, and advances the step by one.
- R4: An unconditional jump (code 2) moves to the destination bank, the destination page and the step given by the argument.
- R5: Every command other than the prefix leaves the destination registers equal to the bank and page of the address it produces. A jump that does not directly follow a prefix therefore changes only the step.
- R6: Codes 3, 4, 5 and 6 jump like code 2 when, in that order, carry is 1, carry is 0, zero is 1 or zero is 0. When the test fails, the step advances by one and any pending prefix is dropped.
- R7: A call (code 7) is busy for three cycles, with `stk_we` high in each of them. It writes the return page to SP-1, the high nibble of the return step to SP-2, and the low nibble to SP-3. The return step is the current step plus one, modulo 256. SP then drops by 3 and the address goes to the target, as for code 2.
- R8: A page-zero call (code 8) saves the return address as in R7. It then moves to page 0 of the current bank, at the step given by the argument, and ignores any prefix.
- R9: A return (code 9) is busy for three cycles, with `stk_re` high in each of them. It reads the low step nibble from SP, the high step nibble from SP+1 and the page from SP+2. It loads them into the address, keeps the current bank, and raises SP by 3.
- R10: A return with skip (code 10) restores the address as in R9 and then adds one to the step, modulo 256, within the restored page.
- R11: A return with data (code 11) restores the address exactly as in R9.
- R12: While `busy` is high, commands are ignored and the address holds. It changes only at the end of the last frame cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A completed instruction is presented this cycle |
| cmd_op | input | 4 | Operation code (see requirements) |
| cmd_arg | input | 8 | Step target, or 5-bit prefix value in bits 4..0 |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| busy | output | 1 | Stack frame in progress; commands ignored |
| pc_addr | output | 13 | {bank, page, step} |
| next_bank | output | 1 | Destination bank register |
| next_page | output | 4 | Destination page register |
| stk_we | output | 1 | Stack nibble write strobe |
| stk_re | output | 1 | Stack nibble read strobe |
| stk_addr | output | 8 | Stack nibble address |
| stk_wdata | output | 4 | Stack write nibble |
| stk_rdata | input | 4 | Stack read nibble, valid in the same cycle as the address |

## Verification
The bench puts a prefix in front of a plain instruction and then issues a jump. A design that kept the prefix alive would leave the current page. It puts a prefix before a page-zero call, and a design that honoured it would land outside page 0. A failed conditional jump placed after a prefix checks that the prefix is dropped. It jumps to step FFh and then advances, so a carry into the page field would show up. Return with skip is run on a saved step of FFh, where a wrong skip would leave the page. Junk commands are driven during every frame; any of them taken would redirect the address or shift the stack pointer, and the nibble order and addresses are checked cycle by cycle.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    localparam int BANK_W    = 1;
    localparam int PAGE_W    = 4;
    localparam int STEP_W    = 8;
    localparam int NIB_W     = 4;
    localparam int ADDR_W    = BANK_W + PAGE_W + STEP_W;
    localparam int STEP_NIBS = STEP_W / NIB_W;
    localparam int FRAME     = 1 + STEP_NIBS;

    typedef enum logic [3:0] {
        OP_SEQ  = 4'd0,
        OP_PSET = 4'd1,
        OP_JP   = 4'd2,
        OP_JPC  = 4'd3,
        OP_JPNC = 4'd4,
        OP_JPZ  = 4'd5,
        OP_JPNZ = 4'd6,
        OP_CALL = 4'd7,
        OP_CALZ = 4'd8,
        OP_RET  = 4'd9,
        OP_RETS = 4'd10,
        OP_RETD = 4'd11
    } pcs_op_e;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [PAGE_W-1:0] page;
        logic [STEP_W-1:0] step;
    } pcs_addr_t;
endpackage

// File: rtl/pcs_branch_unit.sv
module pcs_branch_unit
    import pcs_pkg::*;
(
    input  pcs_op_e             op,
    input  logic [STEP_W-1:0]   arg,
    input  logic                flag_c,
    input  logic                flag_z,
    input  pcs_addr_t           cur,
    input  logic [BANK_W-1:0]   nbank,
    input  logic [PAGE_W-1:0]   npage,
    output pcs_addr_t           seq_addr,
    output pcs_addr_t           far_addr,
    output pcs_addr_t           calz_addr,
    output pcs_addr_t           flow_addr
);
    logic taken;

    always_comb begin
        seq_addr      = cur;
        seq_addr.step = cur.step + 1'b1;
        far_addr      = '{bank: nbank, page: npage, step: arg};
        calz_addr     = '{bank: cur.bank, page: '0, step: arg};
        case (op)
            OP_JP:   taken = 1'b1;
            OP_JPC:  taken = flag_c;
            OP_JPNC: taken = !flag_c;
            OP_JPZ:  taken = flag_z;
            OP_JPNZ: taken = !flag_z;
            default: taken = 1'b0;
        endcase
        flow_addr = taken ? far_addr : seq_addr;
    end
endmodule

// File: rtl/pcs_stack_fsm.sv
module pcs_stack_fsm #(
    parameter int FRAME_LEN = 3,
    localparam int PH_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output logic            busy,
    output logic [PH_W-1:0] phase,
    output logic            last
);
    typedef struct packed {
        logic            busy;
        logic [PH_W-1:0] phase;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        if (!fsm_q.busy) begin
            if (start) begin
                fsm_d.busy  = 1'b1;
                fsm_d.phase = '0;
            end
        end else if (fsm_q.phase == PH_W'(FRAME_LEN - 1)) begin
            fsm_d.busy  = 1'b0;
            fsm_d.phase = '0;
        end else begin
            fsm_d.phase = fsm_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '0;
        else        fsm_q <= fsm_d;
    end

    assign busy  = fsm_q.busy;
    assign phase = fsm_q.phase;
    assign last  = fsm_q.busy && (fsm_q.phase == PH_W'(FRAME_LEN - 1));

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (int'(phase) < FRAME_LEN)) else $error("phase out of range"); // R7
    AST_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && phase == '0)) else $error("frame did not start"); // R9
endmodule

// File: rtl/pcs_sequencer.sv
module pcs_sequencer
    import pcs_pkg::*;
#(
    parameter int SP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_op,
    input  logic [STEP_W-1:0] cmd_arg,
    input  logic              flag_c,
    input  logic              flag_z,
    output logic              busy,
    output logic [ADDR_W-1:0] pc_addr,
    output logic [BANK_W-1:0] next_bank,
    output logic [PAGE_W-1:0] next_page,
    output logic              stk_we,
    output logic              stk_re,
    output logic [SP_W-1:0]   stk_addr,
    output logic [NIB_W-1:0]  stk_wdata,
    input  logic [NIB_W-1:0]  stk_rdata
);
    localparam int PH_W = (FRAME > 1) ? $clog2(FRAME) : 1;

    typedef struct packed {
        pcs_addr_t         pc;
        logic [BANK_W-1:0] nbank;
        logic [PAGE_W-1:0] npage;
        logic [SP_W-1:0]   sp;
        logic              pop;
        logic              skip;
        pcs_addr_t         tgt;
        pcs_addr_t         img;
        logic [STEP_W-1:0] pop_step;
    } seq_state_t;

    localparam seq_state_t RST_STATE = '{
        pc:       '{bank: '0, page: PAGE_W'(1), step: '0},
        nbank:    '0,
        npage:    PAGE_W'(1),
        sp:       '0,
        pop:      1'b0,
        skip:     1'b0,
        tgt:      '0,
        img:      '0,
        pop_step: '0
    };

    seq_state_t st_d, st_q;
    pcs_op_e    op;
    logic       accept;
    logic       start;
    logic       last;
    logic [PH_W-1:0] phase;
    pcs_addr_t  seq_addr, far_addr, calz_addr, flow_addr;

    assign op     = pcs_op_e'(cmd_op);
    assign accept = cmd_valid && !busy;

    pcs_branch_unit u_branch (
        .op        (op),
        .arg       (cmd_arg),
        .flag_c    (flag_c),
        .flag_z    (flag_z),
        .cur       (st_q.pc),
        .nbank     (st_q.nbank),
        .npage     (st_q.npage),
        .seq_addr  (seq_addr),
        .far_addr  (far_addr),
        .calz_addr (calz_addr),
        .flow_addr (flow_addr)
    );

    pcs_stack_fsm #(.FRAME_LEN(FRAME)) u_frame (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .phase (phase),
        .last  (last)
    );

    always_comb begin
        st_d      = st_q;
        start     = 1'b0;
        stk_we    = 1'b0;
        stk_re    = 1'b0;
        stk_addr  = '0;
        stk_wdata = '0;

        if (accept) begin
            case (op)
                OP_PSET: begin
                    st_d.pc    = seq_addr;
                    st_d.nbank = cmd_arg[PAGE_W +: BANK_W];
                    st_d.npage = cmd_arg[PAGE_W-1:0];
                end
                OP_CALL, OP_CALZ: begin
                    start     = 1'b1;
                    st_d.pop  = 1'b0;
                    st_d.skip = 1'b0;
                    st_d.tgt  = (op == OP_CALZ) ? calz_addr : far_addr;
                    st_d.img  = seq_addr;
                end
                OP_RET, OP_RETS, OP_RETD: begin
                    start     = 1'b1;
                    st_d.pop  = 1'b1;
                    st_d.skip = (op == OP_RETS);
                end
                default: begin
                    st_d.pc    = flow_addr;
                    st_d.nbank = flow_addr.bank;
                    st_d.npage = flow_addr.page;
                end
            endcase
        end

        if (busy) begin
            if (!st_q.pop) begin
                stk_we   = 1'b1;
                stk_addr = st_q.sp - SP_W'(phase) - SP_W'(1);
                if (phase == '0)
                    stk_wdata = st_q.img.page;
                else
                    stk_wdata = st_q.img.step[(STEP_NIBS - int'(phase)) * NIB_W +: NIB_W];
                if (last) begin
                    st_d.pc    = st_q.tgt;
                    st_d.nbank = st_q.tgt.bank;
                    st_d.npage = st_q.tgt.page;
                    st_d.sp    = st_q.sp - SP_W'(FRAME);
                end
            end else begin
                stk_re   = 1'b1;
                stk_addr = st_q.sp + SP_W'(phase);
                if (int'(phase) < STEP_NIBS)
                    st_d.pop_step[int'(phase) * NIB_W +: NIB_W] = stk_rdata;
                if (last) begin
                    st_d.pc.page = stk_rdata;
                    st_d.pc.step = st_q.pop_step + STEP_W'(st_q.skip);
                    st_d.npage   = stk_rdata;
                    st_d.nbank   = st_q.pc.bank;
                    st_d.sp      = st_q.sp + SP_W'(FRAME);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_STATE;
        else        st_q <= st_d;
    end

    assign pc_addr   = st_q.pc;
    assign next_bank = st_q.nbank;
    assign next_page = st_q.npage;

    AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_op == OP_SEQ) |=>
        (st_q.pc.step == STEP_W'($past(st_q.pc.step) + 1'b1) && $stable(st_q.pc.page)))
        else $error("sequential step wrong"); // R2
    AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> $stable(st_q.pc)) else $error("address moved while busy"); // R12
    AST_PREFIX_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (cmd_op <= OP_JPNZ || cmd_op >= 4'd12) && cmd_op != OP_PSET) |=>
        (st_q.npage == st_q.pc.page && st_q.nbank == st_q.pc.bank))
        else $error("prefix survived"); // R5
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(stk_we && stk_re)) else $error("stack read and write together"); // R7
    AST_CALL_SP: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !st_q.pop) |=> st_q.sp == $past(st_q.sp) - SP_W'(FRAME))
        else $error("stack pointer not lowered"); // R7
    AST_RET_SP: assert property (@(posedge clk) disable iff (!rst_n)
        (last && st_q.pop) |=> st_q.sp == $past(st_q.sp) + SP_W'(FRAME))
        else $error("stack pointer not raised"); // R9
endmodule

// File: tb/pcs_sequencer_tb_top.sv
module pcs_sequencer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = '0;
    logic [7:0]  cmd_arg = '0;
    logic        flag_c = 1'b0;
    logic        flag_z = 1'b0;
    logic        busy;
    logic [12:0] pc_addr;
    logic        next_bank;
    logic [3:0]  next_page;
    logic        stk_we, stk_re;
    logic [7:0]  stk_addr;
    logic [3:0]  stk_wdata;
    logic [3:0]  stk_rdata;

    logic [3:0]  mem [256];
    logic        pre_we = 1'b0;
    logic [7:0]  pre_addr = '0;
    logic [3:0]  pre_data = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pcs_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .flag_c(flag_c), .flag_z(flag_z), .busy(busy),
        .pc_addr(pc_addr), .next_bank(next_bank), .next_page(next_page),
        .stk_we(stk_we), .stk_re(stk_re), .stk_addr(stk_addr),
        .stk_wdata(stk_wdata), .stk_rdata(stk_rdata)
    );

    assign stk_rdata = mem[stk_addr];

    always @(posedge clk) begin
        if (pre_we)      mem[pre_addr] <= pre_data;
        else if (stk_we) mem[stk_addr] <= stk_wdata;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] op, input logic [7:0] arg);
        cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic run_frame(input logic [3:0] op, input logic [7:0] arg, input bit push,
                             input logic [7:0] sp0, input logic [3:0] d0,
                             input logic [3:0] d1, input logic [3:0] d2, input string req);
        logic [3:0] dat [3];
        dat[0] = d0; dat[1] = d1; dat[2] = d2;
        cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            chk({req, " busy"}, int'(busy), 1);
            if (push) begin
                chk({req, " we"}, int'(stk_we), 1);
                chk({req, " waddr"}, int'(stk_addr), int'(8'(sp0 - 8'(k) - 8'd1)));
                chk({req, " wdata"}, int'(stk_wdata), int'(dat[k]));
            end else begin
                chk({req, " re"}, int'(stk_re), 1);
                chk({req, " raddr"}, int'(stk_addr), int'(8'(sp0 + 8'(k))));
            end
            if (k < 2) begin
                cmd_valid = 1'b1; cmd_op = 4'd2; cmd_arg = 8'h99;
            end else begin
                cmd_valid = 1'b0;
            end
            @(negedge clk);
        end
        chk({req, " busy low"}, int'(busy), 0);
    endtask

    task automatic t_reset();
        chk("R1 addr", int'(pc_addr), 'h0100);
        chk("R1 npage", int'(next_page), 1);
        chk("R1 nbank", int'(next_bank), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 strobes", int'({stk_we, stk_re}), 0);
    endtask

    task automatic t_seq();
        issue(4'd0, 8'h00); issue(4'd0, 8'h00); issue(4'd0, 8'h00);
        chk("R2 seq", int'(pc_addr), 'h0103);
        issue(4'd2, 8'hFF);
        chk("R5 local jump", int'(pc_addr), 'h01FF);
        issue(4'd0, 8'h00);
        chk("R2 wrap", int'(pc_addr), 'h0100);
        issue(4'd15, 8'h77);
        chk("R2 unused code", int'(pc_addr), 'h0101);
    endtask

    task automatic t_pset();
        issue(4'd1, 8'h13);
        chk("R3 nbank", int'(next_bank), 1);
        chk("R3 npage", int'(next_page), 3);
        chk("R3 step", int'(pc_addr), 'h0102);
        issue(4'd2, 8'h40);
        chk("R4 far jump", int'(pc_addr), 'h1340);
        chk("R5 reload", int'({next_bank, next_page}), 'h13);
    endtask

    task automatic t_oneshot();
        issue(4'd1, 8'h05);
        chk("R3 prefix2", int'({next_bank, next_page}), 'h05);
        issue(4'd0, 8'h00);
        chk("R5 dropped", int'({next_bank, next_page}), 'h13);
        issue(4'd2, 8'h22);
        chk("R5 stays", int'(pc_addr), 'h1322);
    endtask

    task automatic t_cond();
        flag_c = 1'b1; flag_z = 1'b0;
        issue(4'd3, 8'h50); chk("R6 c set", int'(pc_addr), 'h1350);
        issue(4'd4, 8'h60); chk("R6 nc fail", int'(pc_addr), 'h1351);
        issue(4'd5, 8'h70); chk("R6 z fail", int'(pc_addr), 'h1352);
        issue(4'd6, 8'h80); chk("R6 nz taken", int'(pc_addr), 'h1380);
        issue(4'd1, 8'h02);
        flag_c = 1'b0;
        issue(4'd3, 8'h10);
        chk("R6 fail step", int'(pc_addr), 'h1382);
        chk("R6 prefix dropped", int'({next_bank, next_page}), 'h13);
        issue(4'd2, 8'h10);
        chk("R6 after", int'(pc_addr), 'h1310);
    endtask

    task automatic t_call();
        issue(4'd1, 8'h07);
        run_frame(4'd7, 8'h33, 1'b1, 8'h00, 4'h3, 4'h1, 4'h2, "R7 call");
        chk("R7 target", int'(pc_addr), 'h0733);
        chk("R12 junk ignored", int'({next_bank, next_page}), 'h07);
        chk("R7 mem", int'({mem[8'hFF], mem[8'hFE], mem[8'hFD]}), 'h312);
        issue(4'd1, 8'h1A);
        run_frame(4'd8, 8'h44, 1'b1, 8'hFD, 4'h7, 4'h3, 4'h5, "R8 calz");
        chk("R8 target", int'(pc_addr), 'h0044);
        chk("R8 npage", int'(next_page), 0);
    endtask

    task automatic t_ret();
        run_frame(4'd9, 8'h00, 1'b0, 8'hFA, 4'h0, 4'h0, 4'h0, "R9 ret");
        chk("R9 restored", int'(pc_addr), 'h0735);
        chk("R9 npage", int'(next_page), 7);
        run_frame(4'd10, 8'h00, 1'b0, 8'hFD, 4'h0, 4'h0, 4'h0, "R10 rets");
        chk("R10 skip", int'(pc_addr), 'h0313);
        pre_we = 1'b1;
        for (int k = 0; k < 6; k++) begin
            pre_addr = 8'(k);
            pre_data = (k == 2) ? 4'h9 : (k == 5) ? 4'h2 : 4'hF;
            @(negedge clk);
        end
        pre_we = 1'b0;
        run_frame(4'd11, 8'h00, 1'b0, 8'h00, 4'h0, 4'h0, 4'h0, "R11 retd");
        chk("R11 restored", int'(pc_addr), 'h09FF);
        run_frame(4'd10, 8'h00, 1'b0, 8'h03, 4'h0, 4'h0, 4'h0, "R10 wrap");
        chk("R10 wrap page", int'(pc_addr), 'h0200);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_seq();
        t_pset();
        t_oneshot();
        t_cond();
        t_call();
        t_ret();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule